// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state of up to eight address-translation contexts behind a 32-bit register port. Each context has its own control word, a table-control word, a bus-control word, a 64-bit table base split into two words, and a memory-attribute word. It also has a fault status word and a captured faulting address. A translation engine outside the block reports faults as single-cycle events tagged with a context index. The block records them and drives one combined interrupt line.

Each context runs its own TLB invalidation handshake. Software sets the flush bit in the control word, and the bit then reads as one until a completion stub finishes the invalidation. That stub takes a programmable number of cycles. Software can therefore poll the bit to learn when the flush is done.

Fault flags do not follow the usual write-one-to-clear rule. A write to the status word keeps only the flags whose bit positions are written as one, so writing zero clears all of them. When no flag remains, the captured address reads as zero. Software must therefore read the address before it clears the status. A second register window can be enabled at offset 0x800, and context 0 can be withheld from use.

Top module: `xctx_bank`

## Requirements
- R1: After reset every register of every context reads 0, `irq` is 0 and `rsp_valid` is 0.
- R2: A register's address is context index × 0x40 plus its offset. The offsets are: control 0x00, table control 0x08, bus control 0x0C, table base low 0x10, table base high 0x14, status 0x20, attribute 0x28, fault address low 0x30 and fault address high 0x34. The five configuration words read back exactly what was written. A read presents its data on `rsp_rdata` with `rsp_valid` high in the cycle after the request is accepted.
- R3: In the control word, bit 0 enables translation, bit 1 requests a flush and bit 2 enables the interrupt. Bits 0 and 2 read back as written. After a write that sets bit 1, bit 1 reads as 1 for exactly `flush_cycles` cycles and then reads 0. A `flush_cycles` value of 0 acts as 1.
- R4: A control write with bit 1 clear does not cancel a flush that is already running, even though it may clear bits 0 and 2. A flush request made while a flush is running does not restart the count.
- R5: A fault event on a context sets status bits from `flt_kind`: kind bit 3 (multiple hit) sets status bit 4, kind bit 2 (walk abort) sets status bit 2, kind bit 1 (page fault) sets status bit 1 and kind bit 0 (translation fault) sets status bit 0. Status bit 3 reads 0. The event address is latched into fault address low (bits 31:0) and high (bits 39:32, zero-extended).
- R6: A status write keeps only the flags whose status bit is written as 1. Writing zero clears every flag.
- R7: Once no status flag is set, both fault address words read 0.
- R8: A fault event on a context that already has a flag set adds its flags but leaves the latched address unchanged.
- R9: `irq` is high exactly when some context has its interrupt enable set and at least one status flag set. It changes directly after the clock edge that changes that state.
- R10: With `NS_ALIAS`=1, addresses with bit 11 set reach the same registers as the same address with bit 11 clear.
- R11: Accesses that map to no register have no effect and read 0. These are: address bits 10:9 non-zero, bit 11 set with `NS_ALIAS`=0, a context index at or above `NUM_CTX`, and context 0 when `RESERVE_CTX0`=1. Fault events on such contexts are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Fault event from the translation engine |
| flt_ctx | input | 3 | Context index of the fault event |
| flt_kind | input | 4 | Fault kinds: multi-hit, walk abort, page fault, translation fault |
| flt_addr | input | VA_W | Faulting address |
| flush_cycles | input | CNT_W | Flush completion latency of the stub |
| irq | output | 1 | Combined fault interrupt |

## Verification
Each result is due at a fixed number of cycles after its stimulus. Read data arrives one cycle after the edge that accepts the read. Status, captured address and `irq` change right after the edge that samples a fault event or a status write. The flush bit stays high for exactly `flush_cycles` polls when the bench reads every cycle after the request. The bench drives inputs on falling edges and samples each output at the next falling edge after the edge that produces it. It counts back-to-back polls to measure the flush window to the cycle. A bench model of flags, captured addresses and enables predicts each status, address and `irq` value in the random phase.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
    localparam int MAX_CTX = 8;
    localparam int IDX_W   = 3;
    localparam int WIN_W   = 6;

    localparam logic [WIN_W-1:0] OFF_CTRL   = 6'h00;
    localparam logic [WIN_W-1:0] OFF_TCR    = 6'h08;
    localparam logic [WIN_W-1:0] OFF_BUS    = 6'h0C;
    localparam logic [WIN_W-1:0] OFF_TBL_LO = 6'h10;
    localparam logic [WIN_W-1:0] OFF_TBL_HI = 6'h14;
    localparam logic [WIN_W-1:0] OFF_STAT   = 6'h20;
    localparam logic [WIN_W-1:0] OFF_ATTR   = 6'h28;
    localparam logic [WIN_W-1:0] OFF_FA_LO  = 6'h30;
    localparam logic [WIN_W-1:0] OFF_FA_HI  = 6'h34;

    localparam int CB_EN    = 0;
    localparam int CB_FLUSH = 1;
    localparam int CB_IRQEN = 2;

    typedef struct packed {
        logic multi_hit;
        logic walk_abort;
        logic page_fault;
        logic xlat_fault;
    } fault_t;

    typedef struct packed {
        logic [31:0] tcr;
        logic [31:0] bus;
        logic [31:0] tbl_lo;
        logic [31:0] tbl_hi;
        logic [31:0] attr;
    } ctx_cfg_t;

    function automatic logic [31:0] status_word(fault_t f);
        return {27'b0, f.multi_hit, 1'b0, f.walk_abort, f.page_fault, f.xlat_fault};
    endfunction

    function automatic fault_t keep_mask(logic [31:0] w);
        return fault_t'({w[4], w[2], w[1], w[0]});
    endfunction
endpackage

// File: rtl/xctx_flush_timer.sv
module xctx_flush_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start && remain == '0) begin
            remain <= (len == '0) ? ONE : len;
        end else if (remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/xctx_slot.sv
module xctx_slot
    import xctx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int VA_W  = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIN_W-1:0] acc_off,
    input  logic [31:0]      wr_data,
    input  logic             flt_hit,
    input  fault_t           flt_kind,
    input  logic [VA_W-1:0]  flt_addr,
    input  logic [CNT_W-1:0] flush_len,
    output logic [31:0]      rd_word,
    output logic             irq_req
);
    logic          xl_en;
    logic          irq_en;
    ctx_cfg_t      cfg;
    fault_t        flags;
    fault_t        kept;
    fault_t        flags_nx;
    logic [VA_W-1:0] faddr;
    logic [VA_W-1:0] faddr_nx;
    logic [63:0]   fa_ext;
    logic          flush_busy;
    logic          flush_go;

    assign flush_go = wr_en && (acc_off == OFF_CTRL) && wr_data[CB_FLUSH];

    xctx_flush_timer #(.CNT_W(CNT_W)) u_flush (
        .clk   (clk),
        .rst   (rst),
        .start (flush_go),
        .len   (flush_len),
        .busy  (flush_busy)
    );

    always_comb begin
        kept = flags;
        if (wr_en && acc_off == OFF_STAT) begin
            kept = fault_t'(flags & keep_mask(wr_data));
        end
        flags_nx = fault_t'(kept | (flt_hit ? flt_kind : fault_t'('0)));
        faddr_nx = faddr;
        if (flt_hit && flt_kind != '0 && kept == '0) begin
            faddr_nx = flt_addr;
        end else if (flags_nx == '0) begin
            faddr_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_en  <= 1'b0;
            irq_en <= 1'b0;
            cfg    <= '0;
            flags  <= '0;
            faddr  <= '0;
        end else begin
            if (wr_en) begin
                case (acc_off)
                    OFF_CTRL: begin
                        xl_en  <= wr_data[CB_EN];
                        irq_en <= wr_data[CB_IRQEN];
                    end
                    OFF_TCR:    cfg.tcr    <= wr_data;
                    OFF_BUS:    cfg.bus    <= wr_data;
                    OFF_TBL_LO: cfg.tbl_lo <= wr_data;
                    OFF_TBL_HI: cfg.tbl_hi <= wr_data;
                    OFF_ATTR:   cfg.attr   <= wr_data;
                    default: ;
                endcase
            end
            flags <= flags_nx;
            faddr <= faddr_nx;
        end
    end

    assign fa_ext = 64'(faddr);

    always_comb begin
        case (acc_off)
            OFF_CTRL:   rd_word = {29'b0, irq_en, flush_busy, xl_en};
            OFF_TCR:    rd_word = cfg.tcr;
            OFF_BUS:    rd_word = cfg.bus;
            OFF_TBL_LO: rd_word = cfg.tbl_lo;
            OFF_TBL_HI: rd_word = cfg.tbl_hi;
            OFF_STAT:   rd_word = status_word(flags);
            OFF_ATTR:   rd_word = cfg.attr;
            OFF_FA_LO:  rd_word = fa_ext[31:0];
            OFF_FA_HI:  rd_word = fa_ext[63:32];
            default:    rd_word = '0;
        endcase
    end

    assign irq_req = irq_en && (flags != '0);
endmodule

// File: rtl/xctx_bank.sv
module xctx_bank
    import xctx_pkg::*;
#(
    parameter int NUM_CTX      = 8,
    parameter bit RESERVE_CTX0 = 1'b0,
    parameter bit NS_ALIAS     = 1'b1,
    parameter int CNT_W        = 8,
    parameter int VA_W         = 40,
    parameter int ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              flt_valid,
    input  logic [IDX_W-1:0]  flt_ctx,
    input  logic [3:0]        flt_kind,
    input  logic [VA_W-1:0]   flt_addr,
    input  logic [CNT_W-1:0]  flush_cycles,
    output logic              irq
);
    localparam int ALIAS_BIT = ADDR_W - 1;
    localparam int PAD_LO    = WIN_W + IDX_W;

    logic [IDX_W-1:0] acc_ctx;
    logic [WIN_W-1:0] acc_off;
    logic             pad_ok;
    logic             alias_ok;
    logic             map_ok;
    logic             do_write;
    logic [31:0]      slot_word [MAX_CTX];
    logic [MAX_CTX-1:0] irq_vec;
    logic [31:0]      rd_data;

    assign acc_ctx  = req_addr[WIN_W +: IDX_W];
    assign acc_off  = req_addr[WIN_W-1:0];
    assign pad_ok   = (req_addr[ALIAS_BIT-1:PAD_LO] == '0);
    assign alias_ok = !req_addr[ALIAS_BIT] || NS_ALIAS;
    assign map_ok   = pad_ok && alias_ok;
    assign do_write = req_valid && req_write && map_ok;

    for (genvar i = 0; i < MAX_CTX; i++) begin : g_ctx
        localparam bit LIVE = (i < NUM_CTX) && !(RESERVE_CTX0 && i == 0);
        if (LIVE) begin : g_slot
            logic wr_sel;
            logic flt_sel;
            assign wr_sel  = do_write && (acc_ctx == IDX_W'(i));
            assign flt_sel = flt_valid && (flt_ctx == IDX_W'(i));
            xctx_slot #(.CNT_W(CNT_W), .VA_W(VA_W)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_sel),
                .acc_off   (acc_off),
                .wr_data   (req_wdata),
                .flt_hit   (flt_sel),
                .flt_kind  (fault_t'(flt_kind)),
                .flt_addr  (flt_addr),
                .flush_len (flush_cycles),
                .rd_word   (slot_word[i]),
                .irq_req   (irq_vec[i])
            );
        end else begin : g_off
            assign slot_word[i] = '0;
            assign irq_vec[i]   = 1'b0;
        end
    end

    assign rd_data = map_ok ? slot_word[acc_ctx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata <= rd_data;
            end
        end
    end

    assign irq = |irq_vec;
endmodule

// File: rtl/xctx_bank_chk.sv
module xctx_bank_chk
    import xctx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              flt_valid,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              irq
);
    localparam int PAD_LO = WIN_W + IDX_W;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!irq && !rsp_valid));

    p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_irq_rise_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(flt_valid || (req_valid && req_write)));

    p_irq_fall_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(req_valid && req_write));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[ADDR_W-2:PAD_LO] != '0) |=> rsp_rdata == 32'h0);
endmodule

bind xctx_bank xctx_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .flt_valid (flt_valid),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
);

// File: tb/sim_xctx_bank.sv
module sim_xctx_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        flt_valid;
    logic [2:0]  flt_ctx;
    logic [3:0]  flt_kind;
    logic [39:0] flt_addr;
    logic [7:0]  flush_cycles;
    logic        rsp_valid0, rsp_valid1, irq0, irq1;
    logic [31:0] rdata0, rdata1;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xctx_bank u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid0),
        .rsp_rdata(rdata0), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
        .flt_kind(flt_kind), .flt_addr(flt_addr), .flush_cycles(flush_cycles),
        .irq(irq0)
    );

    xctx_bank #(.NUM_CTX(4), .RESERVE_CTX0(1'b1), .NS_ALIAS(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid1),
        .rsp_rdata(rdata1), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
        .flt_kind(flt_kind), .flt_addr(flt_addr), .flush_cycles(flush_cycles),
        .irq(irq1)
    );

    // bench model of the default instance
    logic [31:0] m_cfg [8][5];
    logic [3:0]  m_flags [8];
    logic [39:0] m_fa [8];
    logic        m_ie [8];
    logic        m_en [8];
    logic [5:0]  off_tab [5] = '{6'h08, 6'h0C, 6'h10, 6'h14, 6'h28};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r0, output logic [31:0] r1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r0 = rdata0; r1 = rdata1;
        chk("R2 rsp_valid", {31'b0, rsp_valid0}, 32'h1);
    endtask

    task automatic fault(input logic [2:0] c, input logic [3:0] k, input logic [39:0] a);
        flt_valid = 1'b1; flt_ctx = c; flt_kind = k; flt_addr = a;
        @(posedge clk);
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic poll_flush(input logic [11:0] a, output int n);
        logic [31:0] r0, r1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            rd(a, r0, r1);
            if (r0[1]) n++;
            else break;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 5; k++) m_cfg[c][k] = '0;
            m_flags[c] = '0; m_fa[c] = '0; m_ie[c] = 1'b0; m_en[c] = 1'b0;
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [3:0] f);
        return {27'b0, f[3], 1'b0, f[2:0]};
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int c = 0; c < 8; c++) any |= m_ie[c] && (m_flags[c] != 4'h0);
        return any;
    endfunction

    function automatic logic [11:0] caddr(input int c, input logic [5:0] off, input logic alias_on);
        return {alias_on, 2'b00, c[2:0], off};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [31:0] r0, r1;
        int n;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        flt_valid = 0; flt_ctx = '0; flt_kind = '0; flt_addr = '0;
        flush_cycles = 8'd4;
        void'($urandom(32'h5eed_0042));
        do_reset();

        // R1: reset state
        rd(12'h0C0, r0, r1); chk("R1 ctrl ctx3", r0, 0);
        rd(12'h0E0, r0, r1); chk("R1 status ctx3", r0, 0);
        rd(12'h1C8, r0, r1); chk("R1 tcr ctx7", r0, 0);
        chk("R1 irq u0", {31'b0, irq0}, 0);
        chk("R1 irq u1", {31'b0, irq1}, 0);

        // R2 / R11: reserved context 0 on u1
        wr(12'h008, 32'hA5A5_0001);
        rd(12'h008, r0, r1);
        chk("R2 tcr ctx0", r0, 32'hA5A5_0001);
        chk("R11 reserved ctx0", r1, 0);

        // R10 / R11: alias window
        wr(12'h848, 32'h0BAD_F00D);
        rd(12'h048, r0, r1);
        chk("R10 alias write", r0, 32'h0BAD_F00D);
        chk("R11 alias disabled", r1, 0);

        // R11: context beyond NUM_CTX on u1
        wr(12'h148, 32'h1234_ABCD);
        rd(12'h148, r0, r1);
        chk("R2 tcr ctx5", r0, 32'h1234_ABCD);
        chk("R11 ctx above count", r1, 0);

        // R11: pad bits set
        wr(12'h608, 32'hFFFF_FFFF);
        rd(12'h008, r0, r1); chk("R11 pad write ignored", r0, 32'hA5A5_0001);
        rd(12'h608, r0, r1); chk("R11 pad read zero", r0, 0);

        // R9 / R11: fault on ctx0
        wr(12'h000, 32'h4);
        fault(3'd0, 4'b0001, 40'h00_CAFE_0000);
        chk("R9 irq u0", {31'b0, irq0}, 1);
        chk("R11 fault reserved", {31'b0, irq1}, 0);
        rd(12'h020, r0, r1);
        chk("R5 status tf", r0, 32'h1);
        chk("R11 status reserved", r1, 0);
        rd(12'h030, r0, r1); chk("R5 fa lo", r0, 32'hCAFE_0000);
        wr(12'h020, 32'h0);
        chk("R6 irq cleared", {31'b0, irq0}, 0);
        rd(12'h020, r0, r1); chk("R6 status cleared", r0, 0);
        rd(12'h030, r0, r1); chk("R7 fa after clear", r0, 0);

        // R3: flush window
        flush_cycles = 8'd5;
        wr(12'h040, 32'h3);
        poll_flush(12'h040, n);
        chk("R3 flush 5 cycles", n, 5);
        rd(12'h040, r0, r1); chk("R3 ctrl after flush", r0, 32'h1);
        flush_cycles = 8'd0;
        wr(12'h040, 32'h2);
        poll_flush(12'h040, n);
        chk("R3 flush len zero", n, 1);

        // R4: disable does not cancel; re-request does not restart
        flush_cycles = 8'd6;
        wr(12'h080, 32'h7);
        wr(12'h080, 32'h0);
        poll_flush(12'h080, n);
        chk("R4 no cancel", n, 5);
        rd(12'h080, r0, r1); chk("R4 ctrl disabled", r0, 0);
        wr(12'h080, 32'h2);
        wr(12'h080, 32'h2);
        poll_flush(12'h080, n);
        chk("R4 no restart", n, 5);

        // R5 / R8 / R6 / R7 on ctx3
        wr(12'h0C0, 32'h4);
        fault(3'd3, 4'b1010, 40'hAB_1234_5678);
        rd(12'h0E0, r0, r1); chk("R5 status mh+pf", r0, 32'h12);
        rd(12'h0F0, r0, r1); chk("R5 fa lo", r0, 32'h1234_5678);
        rd(12'h0F4, r0, r1); chk("R5 fa hi", r0, 32'hAB);
        fault(3'd3, 4'b0101, 40'h11_0000_0001);
        rd(12'h0E0, r0, r1); chk("R8 flags merge", r0, 32'h17);
        rd(12'h0F0, r0, r1); chk("R8 address kept", r0, 32'h1234_5678);
        wr(12'h0E0, 32'h10);
        rd(12'h0E0, r0, r1); chk("R6 keep bit4", r0, 32'h10);
        chk("R9 irq held", {31'b0, irq0}, 1);
        rd(12'h0F4, r0, r1); chk("R7 fa kept while pending", r0, 32'hAB);
        wr(12'h0E0, 32'h0);
        chk("R9 irq low", {31'b0, irq0}, 0);
        rd(12'h0F4, r0, r1); chk("R7 fa hi cleared", r0, 0);

        // random phase against the model
        do_reset();
        rd(12'h0E0, r0, r1); chk("R1 after second reset", r0, 0);
        for (int it = 0; it < 600; it++) begin
            int op, c, k;
            logic al;
            logic [31:0] d;
            logic [3:0] kd;
            logic [39:0] a;
            op = int'($urandom % 6);
            c  = int'($urandom % 8);
            al = 1'($urandom);
            case (op)
                0: begin
                    k = int'($urandom % 5); d = $urandom;
                    wr(caddr(c, off_tab[k], al), d);
                    m_cfg[c][k] = d;
                end
                1: begin
                    k = int'($urandom % 5);
                    rd(caddr(c, off_tab[k], al), r0, r1);
                    chk(al ? "R10 random cfg" : "R2 random cfg", r0, m_cfg[c][k]);
                end
                2: begin
                    kd = 4'($urandom);
                    a = {8'($urandom), $urandom};
                    fault(3'(c), kd, a);
                    if (kd != 0 && m_flags[c] == 0) m_fa[c] = a;
                    m_flags[c] |= kd;
                    chk("R9 irq after fault", {31'b0, irq0}, {31'b0, exp_irq()});
                end
                3: begin
                    d = ($urandom % 2 == 0) ? 32'h0 : $urandom;
                    wr(caddr(c, 6'h20, al), d);
                    m_flags[c] &= {d[4], d[2], d[1], d[0]};
                    if (m_flags[c] == 0) m_fa[c] = '0;
                    chk("R6 irq after clear", {31'b0, irq0}, {31'b0, exp_irq()});
                end
                4: begin
                    rd(caddr(c, 6'h20, al), r0, r1);
                    chk("R5 random status", r0, exp_status(m_flags[c]));
                    rd(caddr(c, 6'h30, al), r0, r1);
                    chk("R7 random fa lo", r0, m_fa[c][31:0]);
                    rd(caddr(c, 6'h34, al), r0, r1);
                    chk("R8 random fa hi", r0, {24'b0, m_fa[c][39:32]});
                end
                default: begin
                    d = $urandom & 32'h5;
                    wr(caddr(c, 6'h00, al), d);
                    m_en[c] = d[0]; m_ie[c] = d[2];
                    chk("R9 irq after ctrl", {31'b0, irq0}, {31'b0, exp_irq()});
                    rd(caddr(c, 6'h00, al), r0, r1);
                    chk("R3 ctrl readback", r0, {29'b0, m_ie[c], 1'b0, m_en[c]});
                end
            endcase
        end
        finish_run();
    end
endmodule